// File: doc/BRIEF.md
# Windowed Watchdog Timer

A down-counting watchdog with a small register bank on a simple read/write bus. Software sets the reload value and starts the counter with a two-write feed: 0xAA, then 0x55, both written to the feed register. Each later feed reloads the counter. The counter must be fed before it reaches zero. The feed is only accepted once the counter has dropped into a window set by software. Feeding too early, or breaking the two-write sequence, counts as a fault and is handled like an expiry.

When a fault occurs the block always sets a sticky time-out flag. Two outcomes follow, depending on the reset-enable bit:

- With reset-enable set, the block raises a one-cycle reset request and then returns its own registers to their reset values. The time-out flag is kept so software can see why the reset happened.
- With reset-enable clear, the counter stops at zero.

A warning flag sets when the counter passes a programmable compare value. This flag drives the interrupt output until software clears it. The enable, reset-enable, protect and clock-lock bits can be set but never cleared by software. When protect is set, a write to the reload value is accepted only while the counter is below both the warning compare value and the window value. Any other write to the reload value is dropped and sets the time-out flag. The clock-lock bit is only stored and driven out on a pin.

The main controller has four states:

- `CORE_IDLE` (not started)
- `CORE_RUN` (counting)
- `CORE_STOPPED` (expired, counter held at zero)
- `CORE_RSTOUT` (reset request asserted)

Its transitions:

- *start*: from IDLE to RUN, on a valid feed while enabled.
- *fault-stop*: from RUN to STOPPED, on a fault with reset-enable clear.
- *fault-reset*: from RUN to RSTOUT, on a fault with reset-enable set.
- *restart*: from STOPPED to RUN, on a valid feed.
- *release*: from RSTOUT to IDLE, always after one cycle.

The feed sequencer has two states:

- `FEED_WAIT_KEY1`
- `FEED_WAIT_KEY2`

Its transitions:

- *arm*: on 0xAA written to the feed register.
- *complete*: on 0x55 written to the feed register.
- *break*: on any other bus access while armed.

Top module: `wd_window_timer`

## Requirements
- R1: After the reset input, reads return the following:
  - Word addresses: 0 mode, 1 reload value, 2 feed, 3 counter, 4 warning compare, 5 window.
  - Reset values: mode reads 0, reload reads 0xFF, warning compare reads 0, window reads all ones (0x00FFFFFF for a 24-bit counter).
  - `warn_irq`, `rst_req` and `osc_lock` are 0.
- R2: Mode bit 0 (enable), bit 1 (reset-enable), bit 4 (protect) and bit 5 (clock lock) are set by writing 1. Writing 0 leaves them at 1. `osc_lock` equals bit 5.
- R3: The word 0xAA followed directly by 0x55, both written to the feed register (only bits 7:0 are compared), loads the counter from the reload value. While enable is 0 a feed does not start or load the counter.
- R4: While running, the counter decreases by one each clock. It reads the reload value in the cycle after the completing feed write.
- R5: With reset-enable 0, the clock edge after the counter has read zero (with no feed) sets time-out flag bit 2. The counter then stays at zero and `rst_req` stays low.
- R6: With reset-enable 1, a fault raises `rst_req` for exactly one cycle. After it, mode reads 0x4, and the reload, warning and window registers read their reset values.
- R7: Writing 0 to mode bit 2 clears the time-out flag. Writing 1 leaves it unchanged.
- R8: When the running counter equals the warning compare value, mode bit 3 sets on the next edge. `warn_irq` follows it until software writes 0 to bit 3.
- R9: While running, any bus access other than writing 0x55 to the feed register, made after 0xAA was written there, is a fault and is handled like expiry.
- R10: A completing feed while the counter is above the window value is a fault. A feed at or below the window value reloads the counter.
- R11: With protect 0 the reload value can be written at any time. With protect 1 a write to it is accepted only if the counter is below both the warning compare and the window value. Otherwise the register keeps its value and the time-out flag sets.
- R12: Mode bits 31:6 read 0. The counter register ignores writes. The warning compare and window registers read back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Watchdog clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the address |
| warn_irq | output | 1 | Warning interrupt, level |
| rst_req | output | 1 | Watchdog reset request, one-cycle pulse |
| osc_lock | output | 1 | Stored clock-lock bit |

## Verification
The feed path is tried with four patterns:

- A correct feed inside the window, which must reload the counter.
- A correct feed above the window, which must fault.
- A feed broken by an unrelated read, which must fault.
- A feed while disabled, which must do nothing.

Together these separate the window check from the sequence check and from the enable gate. Expiry is run once with reset-enable clear and once with it set. The exact cycle of the flag and of the reset pulse is checked, so an off-by-one in the counter or a longer pulse shows up. The protect gate is tried with one write outside the window and one inside, which separates an accepted write from a blocked one.

// File: rtl/wd_pkg.sv
package wd_pkg;

    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] ADDR_MODE   = 3'd0;
    localparam logic [ADDR_W-1:0] ADDR_RELOAD = 3'd1;
    localparam logic [ADDR_W-1:0] ADDR_FEED   = 3'd2;
    localparam logic [ADDR_W-1:0] ADDR_COUNT  = 3'd3;
    localparam logic [ADDR_W-1:0] ADDR_WARN   = 3'd4;
    localparam logic [ADDR_W-1:0] ADDR_WINDOW = 3'd5;

    localparam int MB_EN    = 0;
    localparam int MB_RSTEN = 1;
    localparam int MB_TOF   = 2;
    localparam int MB_WARN  = 3;
    localparam int MB_PROT  = 4;
    localparam int MB_LOCK  = 5;

    localparam logic [7:0] FEED_KEY1 = 8'hAA;
    localparam logic [7:0] FEED_KEY2 = 8'h55;

    typedef enum logic [1:0] {
        CORE_IDLE    = 2'd0,
        CORE_RUN     = 2'd1,
        CORE_STOPPED = 2'd2,
        CORE_RSTOUT  = 2'd3
    } core_state_t;

    typedef enum logic {
        FEED_WAIT_KEY1 = 1'b0,
        FEED_WAIT_KEY2 = 1'b1
    } feed_state_t;

endpackage

// File: rtl/wd_feed_seq.sv
module wd_feed_seq
    import wd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wkey,
    output logic              feed_ok,
    output logic              seq_err
);

    feed_state_t state_q, state_d;
    logic        key_wr;

    assign key_wr = wr_en && (addr == ADDR_FEED);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= FEED_WAIT_KEY1;
        else if (soft_rst)
            state_q <= FEED_WAIT_KEY1;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FEED_WAIT_KEY1: begin
                if (key_wr && (wkey == FEED_KEY1))
                    state_d = FEED_WAIT_KEY2;
            end
            FEED_WAIT_KEY2: begin
                if (wr_en || rd_en)
                    state_d = FEED_WAIT_KEY1;
            end
        endcase
    end

    always_comb begin
        feed_ok = 1'b0;
        seq_err = 1'b0;
        unique case (state_q)
            FEED_WAIT_KEY1: ;
            FEED_WAIT_KEY2: begin
                if (key_wr && (wkey == FEED_KEY2))
                    feed_ok = 1'b1;
                else if (wr_en || rd_en)
                    seq_err = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/wd_core.sv
module wd_core
    import wd_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             rst_en,
    input  logic             feed_ok,
    input  logic             seq_err,
    input  logic [CNT_W-1:0] reload,
    input  logic [CNT_W-1:0] warn_val,
    input  logic [CNT_W-1:0] win_val,
    output logic [CNT_W-1:0] cnt,
    output logic             warn_hit,
    output logic             fault,
    output logic             soft_rst,
    output logic             rst_req,
    output core_state_t      state_o
);

    localparam logic [CNT_W-1:0] CNT_ZERO = '0;
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    core_state_t state_q, state_d;
    logic        early_feed;
    logic        expired;
    logic        fault_c;

    assign early_feed = feed_ok && (cnt > win_val);
    assign expired    = (cnt == CNT_ZERO) && !feed_ok;
    assign fault_c    = (state_q == CORE_RUN) && (seq_err || early_feed || expired);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= CORE_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CORE_IDLE: begin
                if (en && feed_ok)
                    state_d = CORE_RUN;
            end
            CORE_RUN: begin
                if (fault_c)
                    state_d = rst_en ? CORE_RSTOUT : CORE_STOPPED;
            end
            CORE_STOPPED: begin
                if (feed_ok)
                    state_d = CORE_RUN;
            end
            CORE_RSTOUT: begin
                state_d = CORE_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= CNT_ZERO;
        end else begin
            unique case (state_q)
                CORE_IDLE: begin
                    if (en && feed_ok)
                        cnt <= reload;
                end
                CORE_RUN: begin
                    if (fault_c)
                        cnt <= CNT_ZERO;
                    else if (feed_ok)
                        cnt <= reload;
                    else
                        cnt <= cnt - CNT_ONE;
                end
                CORE_STOPPED: begin
                    if (feed_ok)
                        cnt <= reload;
                    else
                        cnt <= CNT_ZERO;
                end
                CORE_RSTOUT: begin
                    cnt <= CNT_ZERO;
                end
            endcase
        end
    end

    always_comb begin
        warn_hit = 1'b0;
        fault    = 1'b0;
        soft_rst = 1'b0;
        rst_req  = 1'b0;
        unique case (state_q)
            CORE_IDLE:    ;
            CORE_RUN: begin
                warn_hit = (cnt == warn_val);
                fault    = fault_c;
            end
            CORE_STOPPED: ;
            CORE_RSTOUT: begin
                soft_rst = 1'b1;
                rst_req  = 1'b1;
            end
        endcase
    end

    assign state_o = state_q;

endmodule

// File: rtl/wd_regfile.sv
module wd_regfile
    import wd_pkg::*;
#(
    parameter int               CNT_W    = 24,
    parameter logic [CNT_W-1:0] TC_RESET = CNT_W'(255)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              fault,
    input  logic              warn_hit,
    input  logic              soft_rst,
    output logic              en_q,
    output logic              rsten_q,
    output logic              tof_q,
    output logic              warn_q,
    output logic              prot_q,
    output logic              lock_q,
    output logic [CNT_W-1:0]  reload_q,
    output logic [CNT_W-1:0]  warn_val,
    output logic [CNT_W-1:0]  win_val,
    output logic [31:0]       rdata
);

    localparam logic [CNT_W-1:0] WIN_RESET  = '1;
    localparam logic [CNT_W-1:0] WARN_RESET = '0;

    logic             mode_wr;
    logic             reload_wr;
    logic             reload_ok;
    logic [CNT_W-1:0] wfield;

    assign wfield    = wdata[CNT_W-1:0];
    assign mode_wr   = wr_en && (addr == ADDR_MODE);
    assign reload_wr = wr_en && (addr == ADDR_RELOAD);
    assign reload_ok = !prot_q || ((cnt < warn_val) && (cnt < win_val));

    generate
        if (CNT_W < 32) begin : g_sink
            logic unused_hi;
            assign unused_hi = ^wdata[31:CNT_W];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            rsten_q <= 1'b0;
            prot_q  <= 1'b0;
            lock_q  <= 1'b0;
        end else if (soft_rst) begin
            en_q    <= 1'b0;
            rsten_q <= 1'b0;
            prot_q  <= 1'b0;
            lock_q  <= 1'b0;
        end else if (mode_wr) begin
            en_q    <= en_q    | wdata[MB_EN];
            rsten_q <= rsten_q | wdata[MB_RSTEN];
            prot_q  <= prot_q  | wdata[MB_PROT];
            lock_q  <= lock_q  | wdata[MB_LOCK];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            tof_q <= 1'b0;
        else if (fault || (reload_wr && !reload_ok))
            tof_q <= 1'b1;
        else if (mode_wr && !wdata[MB_TOF])
            tof_q <= 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            warn_q <= 1'b0;
        else if (soft_rst)
            warn_q <= 1'b0;
        else if (warn_hit)
            warn_q <= 1'b1;
        else if (mode_wr && !wdata[MB_WARN])
            warn_q <= 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reload_q <= TC_RESET;
            warn_val <= WARN_RESET;
            win_val  <= WIN_RESET;
        end else if (soft_rst) begin
            reload_q <= TC_RESET;
            warn_val <= WARN_RESET;
            win_val  <= WIN_RESET;
        end else if (wr_en) begin
            if (reload_wr && reload_ok)
                reload_q <= wfield;
            if (addr == ADDR_WARN)
                warn_val <= wfield;
            if (addr == ADDR_WINDOW)
                win_val <= wfield;
        end
    end

    always_comb begin
        rdata = 32'd0;
        unique case (addr)
            ADDR_MODE:   rdata = 32'({lock_q, prot_q, warn_q, tof_q, rsten_q, en_q});
            ADDR_RELOAD: rdata = 32'(reload_q);
            ADDR_COUNT:  rdata = 32'(cnt);
            ADDR_WARN:   rdata = 32'(warn_val);
            ADDR_WINDOW: rdata = 32'(win_val);
            default:     rdata = 32'd0;
        endcase
    end

endmodule

// File: rtl/wd_window_timer.sv
module wd_window_timer
    import wd_pkg::*;
#(
    parameter int               CNT_W    = 24,
    parameter logic [CNT_W-1:0] TC_RESET = CNT_W'(255)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              warn_irq,
    output logic              rst_req,
    output logic              osc_lock
);

    logic             feed_ok;
    logic             seq_err;
    logic             fault;
    logic             warn_hit;
    logic             soft_rst;
    logic             en_q;
    logic             rsten_q;
    logic             tof_q;
    logic             warn_q;
    logic             prot_q;
    logic             lock_q;
    logic [CNT_W-1:0] reload_q;
    logic [CNT_W-1:0] warn_val;
    logic [CNT_W-1:0] win_val;
    logic [CNT_W-1:0] cnt;
    core_state_t      core_state;

    wd_feed_seq u_feed (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .wr_en    (bus_wr),
        .rd_en    (bus_rd),
        .addr     (bus_addr),
        .wkey     (bus_wdata[7:0]),
        .feed_ok  (feed_ok),
        .seq_err  (seq_err)
    );

    wd_core #(.CNT_W(CNT_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en_q),
        .rst_en   (rsten_q),
        .feed_ok  (feed_ok),
        .seq_err  (seq_err),
        .reload   (reload_q),
        .warn_val (warn_val),
        .win_val  (win_val),
        .cnt      (cnt),
        .warn_hit (warn_hit),
        .fault    (fault),
        .soft_rst (soft_rst),
        .rst_req  (rst_req),
        .state_o  (core_state)
    );

    wd_regfile #(.CNT_W(CNT_W), .TC_RESET(TC_RESET)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (bus_wr),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .cnt      (cnt),
        .fault    (fault),
        .warn_hit (warn_hit),
        .soft_rst (soft_rst),
        .en_q     (en_q),
        .rsten_q  (rsten_q),
        .tof_q    (tof_q),
        .warn_q   (warn_q),
        .prot_q   (prot_q),
        .lock_q   (lock_q),
        .reload_q (reload_q),
        .warn_val (warn_val),
        .win_val  (win_val),
        .rdata    (bus_rdata)
    );

    assign warn_irq = warn_q;
    assign osc_lock = lock_q;

endmodule

// File: rtl/wd_window_timer_chk.sv
module wd_window_timer_chk
    import wd_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              en_q,
    input logic              lock_q,
    input logic              prot_q,
    input logic              tof_q,
    input logic              warn_irq,
    input logic              rst_req,
    input logic              fault,
    input logic              warn_hit,
    input logic              feed_ok,
    input logic              soft_rst,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  reload_q,
    input logic [CNT_W-1:0]  warn_val,
    input logic [CNT_W-1:0]  win_val,
    input core_state_t       core_state
);

    // R2: set-once bits survive anything but a reset
    p_en_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && !soft_rst) |=> en_q);

    p_lock_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_q && !soft_rst) |=> lock_q);

    // R6: reset request lasts one cycle
    p_rst_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    // R5: every fault leaves the time-out flag set
    p_tof_on_fault_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> tof_q);

    // R5: a stopped counter holds zero
    p_stop_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (core_state == CORE_STOPPED && !feed_ok) |=> (cnt == '0));

    // R4: plain countdown step
    p_count_down_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (core_state == CORE_RUN && !fault && !feed_ok) |=> (cnt == CNT_W'($past(cnt) - 1'b1)));

    // R8: compare match raises the interrupt pin
    p_warn_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
        warn_hit |=> warn_irq);

    // R11: blocked reload write keeps the old value and flags
    p_reload_blocked_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_RELOAD && prot_q && !soft_rst &&
         !((cnt < warn_val) && (cnt < win_val)))
        |=> (reload_q == $past(reload_q)) && tof_q);

endmodule

bind wd_window_timer wd_window_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .en_q       (en_q),
    .lock_q     (lock_q),
    .prot_q     (prot_q),
    .tof_q      (tof_q),
    .warn_irq   (warn_irq),
    .rst_req    (rst_req),
    .fault      (fault),
    .warn_hit   (warn_hit),
    .feed_ok    (feed_ok),
    .soft_rst   (soft_rst),
    .cnt        (cnt),
    .reload_q   (reload_q),
    .warn_val   (warn_val),
    .win_val    (win_val),
    .core_state (core_state)
);

// File: tb/wd_window_timer_test.sv
module wd_window_timer_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        warn_irq;
    logic        rst_req;
    logic        osc_lock;

    int checks = 0;
    int errors = 0;
    int pulses = 0;
    logic done = 1'b0;

    always #2 clk = ~clk;

    wd_window_timer uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .warn_irq  (warn_irq),
        .rst_req   (rst_req),
        .osc_lock  (osc_lock)
    );

    always @(negedge clk) if (rst_req) pulses++;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic feed();
        wr(3'd2, 32'hAA);
        wr(3'd2, 32'h55);
    endtask

    task automatic t_reset_state();
        logic [31:0] v;
        do_reset();
        rd(3'd0, v); chk("R1 mode", v, 32'h0);
        rd(3'd1, v); chk("R1 reload", v, 32'hFF);
        rd(3'd4, v); chk("R1 warn", v, 32'h0);
        rd(3'd5, v); chk("R1 window", v, 32'h00FF_FFFF);
        chk("R1 pins", {29'd0, warn_irq, rst_req, osc_lock}, 32'h0);
    endtask

    task automatic t_sticky();
        logic [31:0] v;
        do_reset();
        wr(3'd0, 32'h33);
        chk("R2 osc_lock", {31'd0, osc_lock}, 32'h1);
        wr(3'd0, 32'h0);
        rd(3'd0, v); chk("R2 sticky", v, 32'h33);
    endtask

    task automatic t_feed_start();
        logic [31:0] v;
        do_reset();
        feed();
        rd(3'd3, v); chk("R3 disabled feed", v, 32'h0);
        wr(3'd0, 32'h1);
        feed();
        rd(3'd3, v); chk("R3 load", v, 32'hFF);
        rd(3'd3, v); chk("R4 decrement", v, 32'hFE);
    endtask

    task automatic t_expire_stop();
        logic [31:0] v;
        int p0;
        do_reset();
        p0 = pulses;
        wr(3'd1, 32'd10);
        wr(3'd0, 32'h1);
        feed();
        repeat (9) @(negedge clk);
        rd(3'd3, v); chk("R4 count", v, 32'd1);
        rd(3'd0, v); chk("R5 no early flag", v & 32'h4, 32'h0);
        rd(3'd0, v); chk("R5 flag", v & 32'h4, 32'h4);
        rd(3'd3, v); chk("R5 held zero", v, 32'h0);
        repeat (3) @(negedge clk);
        rd(3'd3, v); chk("R5 still zero", v, 32'h0);
        chk("R5 no reset pulse", pulses - p0, 32'd0);
        wr(3'd0, 32'h5);
        rd(3'd0, v); chk("R7 write 1 keeps", v & 32'h4, 32'h4);
        wr(3'd0, 32'h1);
        rd(3'd0, v); chk("R7 write 0 clears", v & 32'h4, 32'h0);
    endtask

    task automatic t_expire_reset();
        logic [31:0] v;
        int p0;
        do_reset();
        p0 = pulses;
        wr(3'd1, 32'd10);
        wr(3'd4, 32'd3);
        wr(3'd0, 32'h33);
        feed();
        repeat (11) @(negedge clk);
        chk("R6 pulse high", {31'd0, rst_req}, 32'h1);
        @(negedge clk);
        chk("R6 pulse low", {31'd0, rst_req}, 32'h0);
        rd(3'd0, v); chk("R6 mode after", v, 32'h4);
        rd(3'd1, v); chk("R6 reload after", v, 32'hFF);
        rd(3'd4, v); chk("R6 warn after", v, 32'h0);
        chk("R6 one pulse", pulses - p0, 32'd1);
    endtask

    task automatic t_warning();
        logic [31:0] v;
        do_reset();
        wr(3'd1, 32'd20);
        wr(3'd4, 32'd15);
        wr(3'd0, 32'h1);
        feed();
        repeat (5) @(negedge clk);
        chk("R8 before match", {31'd0, warn_irq}, 32'h0);
        @(negedge clk);
        chk("R8 irq set", {31'd0, warn_irq}, 32'h1);
        rd(3'd0, v); chk("R8 mode bit3", v & 32'h8, 32'h8);
        chk("R8 irq held", {31'd0, warn_irq}, 32'h1);
        wr(3'd0, 32'h1);
        chk("R8 irq cleared", {31'd0, warn_irq}, 32'h0);
    endtask

    task automatic t_broken_seq();
        logic [31:0] v;
        do_reset();
        wr(3'd1, 32'd100);
        wr(3'd0, 32'h1);
        feed();
        wr(3'd2, 32'hAA);
        rd(3'd3, v);
        rd(3'd0, v); chk("R9 broken flag", v & 32'h4, 32'h4);
        rd(3'd3, v); chk("R9 counter stopped", v, 32'h0);
    endtask

    task automatic t_window();
        logic [31:0] v;
        do_reset();
        wr(3'd1, 32'd20);
        wr(3'd5, 32'd5);
        wr(3'd0, 32'h1);
        feed();
        repeat (14) @(negedge clk);
        feed();
        rd(3'd3, v); chk("R10 in-window reload", v, 32'd20);
        rd(3'd0, v); chk("R10 no flag", v & 32'h4, 32'h0);
        feed();
        rd(3'd0, v); chk("R10 early feed flag", v & 32'h4, 32'h4);
        rd(3'd3, v); chk("R10 early feed stops", v, 32'h0);
    endtask

    task automatic t_protect();
        logic [31:0] v;
        do_reset();
        wr(3'd4, 32'd10);
        wr(3'd5, 32'd8);
        wr(3'd1, 32'd50);
        rd(3'd1, v); chk("R11 unprotected write", v, 32'd50);
        wr(3'd0, 32'h11);
        feed();
        wr(3'd1, 32'd30);
        rd(3'd1, v); chk("R11 blocked keeps", v, 32'd50);
        rd(3'd0, v); chk("R11 blocked flag", v & 32'h4, 32'h4);
        wr(3'd0, 32'h11);
        for (int i = 0; i < 100; i++) begin
            rd(3'd3, v);
            if (v < 7) break;
        end
        wr(3'd1, 32'd30);
        rd(3'd1, v); chk("R11 accepted", v, 32'd30);
        rd(3'd0, v); chk("R11 no flag", v & 32'h4, 32'h0);
    endtask

    task automatic t_map();
        logic [31:0] v;
        do_reset();
        wr(3'd4, 32'h123);
        wr(3'd5, 32'h456);
        rd(3'd4, v); chk("R12 warn readback", v, 32'h123);
        rd(3'd5, v); chk("R12 window readback", v, 32'h456);
        wr(3'd0, 32'hFFFF_FFC0);
        rd(3'd0, v); chk("R12 reserved zero", v, 32'h0);
        wr(3'd3, 32'h77);
        rd(3'd3, v); chk("R12 counter read-only", v, 32'h0);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #400000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            finish_run();
        end
    end

    initial begin
        t_reset_state();
        t_sticky();
        t_feed_start();
        t_expire_stop();
        t_expire_reset();
        t_warning();
        t_broken_seq();
        t_window();
        t_protect();
        t_map();
        done = 1'b1;
        finish_run();
    end

endmodule